// File: doc/BRIEF.md
# Multi-Channel Host Register Access Decoder

This block sits between a host processor bus and eight identical per-channel register banks plus a small set of global registers. The host bus is non-multiplexed, with a 12-bit address and a 16-bit data word. A static mode pin selects the strobe style. In one style a data strobe is qualified by a read/write level. In the other, separate read and write strobes are used. All bus strobes are synchronised to the system clock before use. Each write strobe assertion produces exactly one internal write.

The top address nibble chooses the target. Values 0 to 7 select a channel bank. Value 8 writes the same register in every bank in one cycle. A small window at 0x900 to 0x911 holds the global registers. One global register is an interrupt vector: each of its bits is a channel interrupt request gated by a mask bit. Any set vector bit drives an active-low interrupt output. In this project each bank is a plain register file that stands in for the real channel registers.

Top module: `mchan_reg_decoder`

## Requirements
- R1: With `bus_mode`=0, an access happens while `cs_n`=0 and `stb_n`=0. `rw_wrn`=0 makes it a write and `rw_wrn`=1 makes it a read.
- R2: With `bus_mode`=1, `stb_n`=0 is a read strobe and `rw_wrn`=0 is a write strobe, each qualified by `cs_n`=0.
- R3: One write strobe assertion writes exactly once. The write uses the data present two cycles after the strobe is sampled, so a data change later in the same strobe has no effect.
- R4: An address with bits 11:8 equal to 0 through 7 writes and reads only that channel's bank. The other banks stay unchanged.
- R5: A write with address bits 11:8 equal to 8 stores the data at offset bits 7:0 in all eight banks.
- R6: A read of the broadcast range, of any address outside the banks and 0x900-0x911, or of a bank offset at or above 0x20, returns 0x0000. A write to an unmapped address changes no register.
- R7: At 0x900 a read returns `chan_irq` AND mask in bits 7:0, with zeros above, and writes there are ignored. The mask is bits 7:0 of 0x901, and its upper bits read 0. Addresses 0x902-0x911 are 16-bit read/write registers.
- R8: `irq_n` is 0 exactly when the interrupt vector read at 0x900 is nonzero. It follows `chan_irq` and the mask with one cycle of delay.
- R9: `rdata` carries the addressed value from the third rising clock edge after the read strobe is first sampled, and is 0x0000 whenever no read is in progress.
- R10: After reset every register is 0, `rdata` is 0x0000 and `irq_n` is 1.
- R11: With `cs_n`=1 the strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 1 | Static strobe style: 0 data strobe plus read/write level, 1 separate strobes |
| cs_n | input | 1 | Chip select, active low |
| stb_n | input | 1 | Data strobe (mode 0) or read strobe (mode 1), active low |
| rw_wrn | input | 1 | Read/write level (mode 0, 1 = read) or write strobe (mode 1, active low) |
| addr | input | 12 | Host address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Registered read data |
| chan_irq | input | 8 | Per-channel interrupt requests |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
The bench holds a write strobe for several cycles and changes the data in mid-strobe. A design that re-triggered on a held strobe would store the late value. Broadcast writes are read back from the first and last banks, and a read of the broadcast address itself must return zero. A design that aliased that range onto bank 0 would return the stored data instead. The bench also writes the read-only vector register, writes the upper mask bits, and writes through a deselected chip select. A design that leaked any of these would change what a later read returns or would move the interrupt output. Both strobe styles run the same sequences, and a cycle-accurate model checks read data and the interrupt on every clock.

// File: rtl/mra_pkg.sv
package mra_pkg;
    parameter int unsigned ADDR_W    = 12;
    parameter int unsigned DATA_W    = 16;
    parameter int unsigned NUM_CH    = 8;
    parameter int unsigned BANK_REGS = 32;
    parameter int unsigned GLOB_CNT  = 18;

    localparam int unsigned CH_W    = $clog2(NUM_CH);
    localparam int unsigned SEL_W   = 4;
    localparam int unsigned OFF_W   = ADDR_W - SEL_W;
    localparam int unsigned GIDX_W  = $clog2(GLOB_CNT);
    localparam logic [SEL_W-1:0] BCAST_SEL = 4'h8;
    localparam logic [SEL_W-1:0] GLOB_SEL  = 4'h9;

    typedef struct packed {
        logic              bank_hit;
        logic [CH_W-1:0]   bank;
        logic              bcast;
        logic              glob_hit;
        logic [GIDX_W-1:0] glob_idx;
        logic [OFF_W-1:0]  off;
    } dec_t;
endpackage

// File: rtl/mra_strobe_sync.sv
module mra_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_mode,
    input  logic cs_n,
    input  logic stb_n,
    input  logic rw_wrn,
    output logic rd_act,
    output logic wr_pulse
);
    localparam logic [2:0] IDLE_PINS = 3'b111;

    typedef struct packed {
        logic [2:0] s1;
        logic [2:0] s2;
        logic       wr_prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     wr_act;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = {cs_n, stb_n, rw_wrn};
        st_d.s2 = st_q.s1;
        if (bus_mode == 1'b0) begin
            rd_act = !st_q.s2[2] && !st_q.s2[1] &&  st_q.s2[0];
            wr_act = !st_q.s2[2] && !st_q.s2[1] && !st_q.s2[0];
        end else begin
            rd_act = !st_q.s2[2] && !st_q.s2[1];
            wr_act = !st_q.s2[2] && !st_q.s2[0];
        end
        wr_pulse     = wr_act && !st_q.wr_prev;
        st_d.wr_prev = wr_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: IDLE_PINS, s2: IDLE_PINS, wr_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assert_one_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);
endmodule

// File: rtl/mra_addr_dec.sv
module mra_addr_dec
    import mra_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [OFF_W:0]   GLOB_LIM = (OFF_W+1)'(GLOB_CNT);
    localparam logic [SEL_W:0]   CH_LIM   = (SEL_W+1)'(NUM_CH);

    logic [SEL_W-1:0] sel;
    logic [OFF_W-1:0] off;

    always_comb begin
        sel          = addr[ADDR_W-1:OFF_W];
        off          = addr[OFF_W-1:0];
        dec          = '0;
        dec.off      = off;
        dec.bank     = sel[CH_W-1:0];
        dec.bank_hit = ({1'b0, sel} < CH_LIM);
        dec.bcast    = (sel == BCAST_SEL);
        dec.glob_hit = (sel == GLOB_SEL) && ({1'b0, off} < GLOB_LIM);
        dec.glob_idx = off[GIDX_W-1:0];
    end
endmodule

// File: rtl/mra_bank.sv
module mra_bank #(
    parameter int unsigned DW    = 16,
    parameter int unsigned REGS  = 32,
    parameter int unsigned OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [OFF_W-1:0] off,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    localparam int unsigned IDX_W = $clog2(REGS);
    localparam logic [OFF_W:0] LIM = (OFF_W+1)'(REGS);

    typedef struct packed {
        logic [REGS-1:0][DW-1:0] regs;
    } bank_st_t;

    bank_st_t         st_d, st_q;
    logic             in_range;
    logic [IDX_W-1:0] idx;

    always_comb begin
        in_range = ({1'b0, off} < LIM);
        idx      = off[IDX_W-1:0];
        st_d     = st_q;
        if (we && in_range) begin
            st_d.regs[idx] = wdata;
        end
        rdata = in_range ? st_q.regs[idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(st_q));
endmodule

// File: rtl/mra_glob.sv
module mra_glob #(
    parameter int unsigned DW     = 16,
    parameter int unsigned NCH    = 8,
    parameter int unsigned CNT    = 18,
    parameter int unsigned IDX_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    input  logic [NCH-1:0]   req,
    output logic [DW-1:0]    rdata,
    output logic             irq_n
);
    localparam int unsigned GP = CNT - 2;

    typedef struct packed {
        logic [NCH-1:0]        vec;
        logic [NCH-1:0]        mask;
        logic [GP-1:0][DW-1:0] gp;
        logic                  irq;
    } glob_st_t;

    glob_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vec = req & st_q.mask;
        st_d.irq = |(req & st_q.mask);
        rdata    = '0;
        if (idx == IDX_W'(0)) begin
            rdata = {{(DW-NCH){1'b0}}, st_q.vec};
        end else if (idx == IDX_W'(1)) begin
            rdata = {{(DW-NCH){1'b0}}, st_q.mask};
            if (we) begin
                st_d.mask = wdata[NCH-1:0];
            end
        end
        for (int k = 0; k < int'(GP); k++) begin
            if (idx == IDX_W'(k + 2)) begin
                rdata = st_q.gp[k];
                if (we) begin
                    st_d.gp[k] = wdata;
                end
            end
        end
        irq_n = !st_q.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_irq_matches_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(|st_q.vec));

    assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == IDX_W'(1)) |=> st_q.mask == $past(wdata[NCH-1:0]));
endmodule

// File: rtl/mchan_reg_decoder.sv
module mchan_reg_decoder
    import mra_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_mode,
    input  logic              cs_n,
    input  logic              stb_n,
    input  logic              rw_wrn,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_CH-1:0] chan_irq,
    output logic              irq_n
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic              rd_act;
    logic              wr_pulse;
    dec_t              dec;
    logic [DATA_W-1:0] bank_rd [NUM_CH];
    logic [DATA_W-1:0] glob_rd;
    logic              glob_we;

    mra_strobe_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_mode (bus_mode),
        .cs_n     (cs_n),
        .stb_n    (stb_n),
        .rw_wrn   (rw_wrn),
        .rd_act   (rd_act),
        .wr_pulse (wr_pulse)
    );

    mra_addr_dec u_dec (
        .addr (addr),
        .dec  (dec)
    );

    for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_pulse &&
                         (dec.bcast || (dec.bank_hit && dec.bank == CH_W'(i)));
        mra_bank #(
            .DW    (DATA_W),
            .REGS  (BANK_REGS),
            .OFF_W (OFF_W)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we),
            .off   (dec.off),
            .wdata (wdata),
            .rdata (bank_rd[i])
        );
    end

    assign glob_we = wr_pulse && dec.glob_hit;

    mra_glob #(
        .DW    (DATA_W),
        .NCH   (NUM_CH),
        .CNT   (GLOB_CNT),
        .IDX_W (GIDX_W)
    ) u_glob (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (glob_we),
        .idx   (dec.glob_idx),
        .wdata (wdata),
        .req   (chan_irq),
        .rdata (glob_rd),
        .irq_n (irq_n)
    );

    always_comb begin
        st_d.rdata = '0;
        if (rd_act) begin
            if (dec.bank_hit) begin
                st_d.rdata = bank_rd[dec.bank];
            end else if (dec.glob_hit) begin
                st_d.rdata = glob_rd;
            end
        end
        rdata = st_q.rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_idle_rdata_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |=> rdata == '0);

    assert_unmapped_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !dec.bank_hit && !dec.glob_hit) |=> rdata == '0);
endmodule

// File: tb/mchan_reg_decoder_tb_top.sv
`timescale 1ns/100ps
module mchan_reg_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_mode = 1'b0;
    logic        cs_n = 1'b1;
    logic        stb_n = 1'b1;
    logic        rw_wrn = 1'b1;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [7:0]  chan_irq = '0;
    logic        irq_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    mchan_reg_decoder dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_mode (bus_mode),
        .cs_n     (cs_n),
        .stb_n    (stb_n),
        .rw_wrn   (rw_wrn),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .chan_irq (chan_irq),
        .irq_n    (irq_n)
    );

    // behavioural reference model
    logic [15:0] m_bank [8][256];
    logic [15:0] m_gp   [18];
    logic [7:0]  m_vec, m_mask;
    logic [2:0]  m_p1, m_p2;
    logic        m_prev;
    logic [15:0] exp_rdata = '0;
    logic        exp_irq = 1'b0;

    function automatic logic [15:0] m_lookup(input logic [11:0] a);
        if (a[11:8] < 4'd8) return (a[7:0] < 8'd32) ? m_bank[a[11:8]][a[7:0]] : 16'h0;
        if (a == 12'h900) return {8'h0, m_vec};
        if (a == 12'h901) return {8'h0, m_mask};
        if (a >= 12'h902 && a <= 12'h911) return m_gp[a - 12'h900];
        return 16'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 8; c++)
                for (int r = 0; r < 256; r++) m_bank[c][r] = '0;
            for (int g = 0; g < 18; g++) m_gp[g] = '0;
            m_vec = '0; m_mask = '0; m_p1 = 3'b111; m_p2 = 3'b111; m_prev = 1'b0;
            exp_rdata = '0; exp_irq = 1'b0;
        end else begin
            logic rd, wr, pulse;
            logic [7:0] old_mask;
            if (!bus_mode) begin
                rd = !m_p2[2] && !m_p2[1] && m_p2[0];
                wr = !m_p2[2] && !m_p2[1] && !m_p2[0];
            end else begin
                rd = !m_p2[2] && !m_p2[1];
                wr = !m_p2[2] && !m_p2[0];
            end
            pulse    = wr && !m_prev;
            m_prev   = wr;
            old_mask = m_mask;
            exp_rdata = rd ? m_lookup(addr) : 16'h0;
            if (pulse) begin
                if (addr[11:8] < 4'd8) begin
                    if (addr[7:0] < 8'd32) m_bank[addr[11:8]][addr[7:0]] = wdata;
                end else if (addr[11:8] == 4'd8) begin
                    if (addr[7:0] < 8'd32)
                        for (int c = 0; c < 8; c++) m_bank[c][addr[7:0]] = wdata;
                end else if (addr == 12'h901) begin
                    m_mask = wdata[7:0];
                end else if (addr >= 12'h902 && addr <= 12'h911) begin
                    m_gp[addr - 12'h900] = wdata;
                end
            end
            m_vec   = chan_irq & old_mask;
            exp_irq = |m_vec;
            m_p2 = m_p1;
            m_p1 = {cs_n, stb_n, rw_wrn};
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            checks++;
            if (rdata !== exp_rdata) begin
                fails++;
                $display("FAIL R9 per-cycle rdata: actual %h expected %h", rdata, exp_rdata);
            end
            checks++;
            if (irq_n !== !exp_irq) begin
                fails++;
                $display("FAIL R8 per-cycle irq_n: actual %b expected %b", irq_n, !exp_irq);
            end
        end
        if (cycles > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic go_idle();
        cs_n = 1'b1; stb_n = 1'b1; rw_wrn = 1'b1;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [15:0] d1,
                             input logic [15:0] d2, input logic cs_val);
        @(negedge clk);
        addr = a; wdata = d1; cs_n = cs_val; rw_wrn = 1'b0;
        stb_n = bus_mode ? 1'b1 : 1'b0;
        repeat (4) @(negedge clk);
        wdata = d2;
        repeat (4) @(negedge clk);
        go_idle();
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; cs_n = 1'b0; stb_n = 1'b0; rw_wrn = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 no data before third edge", rdata, 16'h0);
        @(negedge clk);
        v = rdata;
        go_idle();
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        bus_write(a, d, d, 1'b0);
    endtask

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        check("R10 rdata in reset", rdata, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 irq_n after reset", {15'h0, irq_n}, 16'h1);
        bus_read(12'h10A, v); check("R10 bank reg after reset", v, 16'h0);
        bus_read(12'h905, v); check("R10 global reg after reset", v, 16'h0);

        for (int md = 0; md < 2; md++) begin
            bus_mode = md[0];
            wr(12'h305, 16'h1234 ^ 16'(md));
            bus_read(12'h305, v); check(md ? "R2 intel rw" : "R1 moto rw", v, 16'h1234 ^ 16'(md));
            bus_read(12'h205, v); check("R4 other bank untouched", v, 16'h0);
            bus_write(12'h71F, 16'h0111, 16'h0222, 1'b0);
            bus_read(12'h71F, v); check("R3 single write per strobe", v, 16'h0111);
            bus_write(12'h305, 16'hFFFF, 16'hFFFF, 1'b1);
            bus_read(12'h305, v); check("R11 deselected ignored", v, 16'h1234 ^ 16'(md));
        end

        bus_mode = 1'b0;
        wr(12'h812, 16'hBEEF);
        bus_read(12'h012, v); check("R5 broadcast bank0", v, 16'hBEEF);
        bus_read(12'h712, v); check("R5 broadcast bank7", v, 16'hBEEF);
        bus_read(12'h812, v); check("R6 broadcast read zero", v, 16'h0);
        wr(12'h340, 16'h5555);
        bus_read(12'h340, v); check("R6 out-of-range offset", v, 16'h0);
        wr(12'hA00, 16'h6666);
        bus_read(12'hA00, v); check("R6 unmapped read", v, 16'h0);
        bus_read(12'h912, v); check("R6 past global window", v, 16'h0);
        bus_read(12'h000, v); check("R6 unmapped write no alias", v, 16'h0);

        bus_mode = 1'b1;
        wr(12'h911, 16'h7777);
        bus_read(12'h911, v); check("R7 global rw", v, 16'h7777);
        chan_irq = 8'h05;
        repeat (3) @(negedge clk);
        check("R8 masked request no irq", {15'h0, irq_n}, 16'h1);
        wr(12'h901, 16'hFF04);
        bus_read(12'h901, v); check("R7 mask upper bits zero", v, 16'h0004);
        bus_read(12'h900, v); check("R7 vector value", v, 16'h0004);
        check("R8 irq asserted", {15'h0, irq_n}, 16'h0);
        wr(12'h900, 16'hFFFF);
        bus_read(12'h900, v); check("R7 vector read-only", v, 16'h0004);
        chan_irq = 8'h01;
        @(negedge clk);
        @(negedge clk);
        check("R8 irq released", {15'h0, irq_n}, 16'h1);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule